// File: doc/BRIEF.md
# Flash Protection Command Register Block

This block is the register front end of a serial NOR flash controller. It sits on a simple word-addressed register bus and keeps the write-protection state of the flash array. It decodes operation words into bulk-erase, sector-erase and protect commands. It checks every erase request and every memory-port write against the protected region. Accepted requests go to a downstream flash sequencer as one-cycle pulses. Refused requests produce no pulse. Instead they set a sticky interrupt flag, which software clears by writing a one to it.

The protected region is a power-of-two number of 64 KiB sectors. A 4-bit protect level sets that number, and a bottom-anchor bit places the region at address zero; when the bit is clear the region sits at the top of the array. The array size follows from the low byte of the device identifier that the sequencer supplies.

Top module: `flashprot_top`

## Requirements
- R1: While and after reset, the protect level, anchor, interrupt flags, mask, chip select and last operation word are zero, no output pulse is active, and irq_o is low.
- R2: The register at word offset 0 (status) can only be read, and a bus write to it has no effect. Offsets 1 and 2 return sid_i and devid_i. Offsets 3, 5 and 6 return the last value written, masked to the implemented width: 32 bits, 2 bits and CS_W bits. Offset 7 reads as zero.
- R3: An operation word with opcode 3 in bits 3:0 loads the protect level from bits 11:8 and the anchor from bit 12, and pulses op_prot_o on the following cycle. The status register then reports level bits 2:0 in bits 4:2, level bit 3 in bit 6 and the anchor in bit 5. No other event changes these fields.
- R4: The array has N = 2^n sectors, where n is the low byte of devid_i minus (SECT_SHIFT+6), held to the range 0 to SECT_W. For a level L of zero nothing is protected. For L > 0 the protected count is C = 2^min(L-1, n). Sector s is protected if s < C when the anchor is 1, and if s >= N-C when the anchor is 0.
- R5: An operation word with opcode 2 asks to erase the sector given in bits 8 upward. If that sector is unprotected, op_sect_o pulses one cycle later and op_sect_idx_o carries the sector number.
- R6: A sector erase aimed at a protected sector produces no pulse and sets interrupt flag bit 0 on the following cycle.
- R7: Opcode 1 (bulk erase) pulses op_bulk_o one cycle later only when the level is zero. Otherwise it produces no pulse and sets flag bit 0.
- R8: A memory-port write strobe to an unprotected sector pulses wr_ok_o one cycle later. A strobe to a protected sector produces no pulse and sets flag bit 1.
- R9: Writing a 1 to a bit at offset 4 clears that flag. If a flag is cleared and set in the same cycle, the set wins.
- R10: irq_o is high exactly when some flag bit and the matching bit at offset 5 are both 1. With IRQ_REG = 0 it follows in the same cycle as the flags.
- R11: An operation word whose opcode is not 1, 2 or 3 produces no pulse and changes neither the protection state nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 3 | Word offset for reads and writes |
| bus_we_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| sid_i | input | 32 | Silicon identifier from the sequencer |
| devid_i | input | 32 | Device identifier; the low byte sets the array size |
| mem_wr_i | input | 1 | Memory-port write strobe |
| mem_wr_addr_i | input | ADDR_W | Byte address of the memory-port write |
| op_bulk_o | output | 1 | Bulk-erase command pulse |
| op_sect_o | output | 1 | Sector-erase command pulse |
| op_sect_idx_o | output | ADDR_W-SECT_SHIFT | Sector to erase |
| op_prot_o | output | 1 | Protect-update command pulse |
| op_prot_level_o | output | 4 | Current protect level |
| op_prot_bottom_o | output | 1 | Current bottom-anchor bit |
| wr_ok_o | output | 1 | Memory write accepted pulse |
| csel_o | output | CS_W | Chip-select register value |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest part to reach is the boundary of the protected region. The boundary moves with three inputs at once: the level, the anchor and the array size that comes from devid_i. The clamp where 2^(L-1) exceeds the array only occurs when a high level meets a small array. The bench uses a 16-sector configuration. It sweeps devid values that cover every array size, including both clamp ends, together with every level and both anchors. At each setting it fires a sector erase and a memory write at every sector and compares the result with the formula. Set-wins-over-clear needs a refused write and a flag clear in the same cycle, so the bench drives both strobes on one edge.

// File: rtl/flashprot_pkg.sv
package flashprot_pkg;

   localparam int REG_AW = 3;

   typedef enum logic [2:0] {
      OFS_STATUS = 3'd0,
      OFS_SID    = 3'd1,
      OFS_DEVID  = 3'd2,
      OFS_MEMOP  = 3'd3,
      OFS_ISR    = 3'd4,
      OFS_IMR    = 3'd5,
      OFS_CSEL   = 3'd6
   } reg_ofs_e;

   localparam logic [3:0] OPC_BULK = 4'd1;
   localparam logic [3:0] OPC_SECT = 4'd2;
   localparam logic [3:0] OPC_PROT = 4'd3;

   localparam int FLAG_ERASE = 0;
   localparam int FLAG_WRITE = 1;
   localparam int NUM_FLAGS  = 2;

   typedef struct packed {
      logic [3:0] level;
      logic       bottom;
   } prot_cfg_t;

endpackage

// File: rtl/flashprot_range.sv
module flashprot_range
   import flashprot_pkg::*;
#(
   parameter int SECT_W = 10,
   localparam int NLW   = $clog2(SECT_W + 1),
   localparam int LW    = SECT_W + 1
) (
   input  prot_cfg_t          cfg_i,
   input  logic [NLW-1:0]     nlog_i,
   input  logic [SECT_W-1:0]  sect_i,
   output logic               hit_o
);

   logic [7:0]    shl;
   logic [7:0]    nl;
   logic [7:0]    len_log;
   logic [LW-1:0] nsect;
   logic [LW-1:0] len;
   logic [LW-1:0] sect_x;

   always_comb begin
      nl      = 8'(nlog_i);
      shl     = {4'd0, cfg_i.level} - 8'd1;
      len_log = (shl > nl) ? nl : shl;
      nsect   = LW'(1) << nl;
      len     = LW'(1) << len_log;
      sect_x  = {1'b0, sect_i};
      if (cfg_i.level == 4'd0) begin
         hit_o = 1'b0;
      end else if (cfg_i.bottom) begin
         hit_o = sect_x < len;
      end else begin
         hit_o = sect_x >= (nsect - len);
      end
   end

   always_comb begin
      if (cfg_i.level == 4'd0) begin
         assert_level0_clear_R4 : assert (!hit_o);
      end
      assert_len_fits_R4 : assert (len <= nsect);
   end

endmodule

// File: rtl/flashprot_cmd.sv
module flashprot_cmd
   import flashprot_pkg::*;
#(
   parameter int SECT_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              memop_we_i,
   input  logic [31:0]       memop_wdata_i,
   input  logic              erase_hit_i,
   input  logic              mem_wr_i,
   input  logic              write_hit_i,
   output prot_cfg_t         cfg_o,
   output logic              op_bulk_o,
   output logic              op_sect_o,
   output logic [SECT_W-1:0] op_sect_idx_o,
   output logic              op_prot_o,
   output logic              wr_ok_o,
   output logic              erase_refused_o,
   output logic              write_refused_o,
   output logic              prot_fire_o
);

   logic [3:0] opc;
   logic       bulk_req;
   logic       sect_req;
   logic       prot_req;
   logic       any_prot;
   prot_cfg_t  cfg_q;

   assign opc      = memop_wdata_i[3:0];
   assign bulk_req = memop_we_i && (opc == OPC_BULK);
   assign sect_req = memop_we_i && (opc == OPC_SECT);
   assign prot_req = memop_we_i && (opc == OPC_PROT);
   assign any_prot = (cfg_q.level != 4'd0);

   assign erase_refused_o = (bulk_req && any_prot) || (sect_req && erase_hit_i);
   assign write_refused_o = mem_wr_i && write_hit_i;
   assign prot_fire_o     = prot_req;
   assign cfg_o           = cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q         <= '0;
         op_bulk_o     <= 1'b0;
         op_sect_o     <= 1'b0;
         op_sect_idx_o <= '0;
         op_prot_o     <= 1'b0;
         wr_ok_o       <= 1'b0;
      end else begin
         op_bulk_o <= bulk_req && !any_prot;
         op_sect_o <= sect_req && !erase_hit_i;
         op_prot_o <= prot_req;
         wr_ok_o   <= mem_wr_i && !write_hit_i;
         if (sect_req && !erase_hit_i) begin
            op_sect_idx_o <= memop_wdata_i[8 +: SECT_W];
         end
         if (prot_req) begin
            cfg_q.level  <= memop_wdata_i[11:8];
            cfg_q.bottom <= memop_wdata_i[12];
         end
      end
   end

   assert_bulk_refused_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (bulk_req && any_prot) |=> !op_bulk_o);

   assert_sect_refused_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (memop_we_i && memop_wdata_i[3:0] == OPC_SECT && erase_hit_i) |=> !op_sect_o);

   assert_pulses_exclusive_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op_bulk_o, op_sect_o, op_prot_o}));

endmodule

// File: rtl/flashprot_top.sv
module flashprot_top
   import flashprot_pkg::*;
#(
   parameter int ADDR_W     = 26,
   parameter int SECT_SHIFT = 16,
   parameter int CS_W       = 2,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [2:0]                   bus_addr_i,
   input  logic                         bus_we_i,
   input  logic [31:0]                  bus_wdata_i,
   output logic [31:0]                  bus_rdata_o,
   input  logic [31:0]                  sid_i,
   input  logic [31:0]                  devid_i,
   input  logic                         mem_wr_i,
   input  logic [ADDR_W-1:0]            mem_wr_addr_i,
   output logic                         op_bulk_o,
   output logic                         op_sect_o,
   output logic [ADDR_W-SECT_SHIFT-1:0] op_sect_idx_o,
   output logic                         op_prot_o,
   output logic [3:0]                   op_prot_level_o,
   output logic                         op_prot_bottom_o,
   output logic                         wr_ok_o,
   output logic [CS_W-1:0]              csel_o,
   output logic                         irq_o
);

   localparam int SECT_W   = ADDR_W - SECT_SHIFT;
   localparam int NLW      = $clog2(SECT_W + 1);
   localparam int DEV_BIAS = SECT_SHIFT + 6;

   if (SECT_W < 1) begin : g_bad_sect
      $error("ADDR_W must exceed SECT_SHIFT");
   end
   if (SECT_W + 8 > 32) begin : g_bad_field
      $error("sector number does not fit the operation word");
   end
   if (CS_W < 1 || CS_W > 32) begin : g_bad_cs
      $error("CS_W must be 1..32");
   end
   if (DEV_BIAS > 255) begin : g_bad_bias
      $error("SECT_SHIFT too large for the device byte");
   end

   logic [31:0]          memop_q;
   logic [NUM_FLAGS-1:0] imr_q;
   logic [NUM_FLAGS-1:0] isr_q;
   logic [NUM_FLAGS-1:0] flag_set;
   logic [CS_W-1:0]      csel_q;
   logic                 memop_we;
   logic                 isr_we;
   logic [NLW-1:0]       nlog;
   prot_cfg_t            cfg;
   logic                 erase_refused;
   logic                 write_refused;
   logic                 prot_fire;
   logic [SECT_W-1:0]    query [2];
   logic                 hit   [2];

   assign memop_we = bus_we_i && (bus_addr_i == OFS_MEMOP);
   assign isr_we   = bus_we_i && (bus_addr_i == OFS_ISR);

   always_comb begin
      if (devid_i[7:0] < 8'(DEV_BIAS)) begin
         nlog = '0;
      end else if ((devid_i[7:0] - 8'(DEV_BIAS)) > 8'(SECT_W)) begin
         nlog = NLW'(SECT_W);
      end else begin
         nlog = NLW'(devid_i[7:0] - 8'(DEV_BIAS));
      end
   end

   assign query[0] = bus_wdata_i[8 +: SECT_W];
   assign query[1] = mem_wr_addr_i[ADDR_W-1:SECT_SHIFT];

   for (genvar q = 0; q < 2; q++) begin : g_range
      flashprot_range #(.SECT_W(SECT_W)) range_i (
         .cfg_i  (cfg),
         .nlog_i (nlog),
         .sect_i (query[q]),
         .hit_o  (hit[q])
      );
   end

   flashprot_cmd #(.SECT_W(SECT_W)) cmd_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .memop_we_i      (memop_we),
      .memop_wdata_i   (bus_wdata_i),
      .erase_hit_i     (hit[0]),
      .mem_wr_i        (mem_wr_i),
      .write_hit_i     (hit[1]),
      .cfg_o           (cfg),
      .op_bulk_o       (op_bulk_o),
      .op_sect_o       (op_sect_o),
      .op_sect_idx_o   (op_sect_idx_o),
      .op_prot_o       (op_prot_o),
      .wr_ok_o         (wr_ok_o),
      .erase_refused_o (erase_refused),
      .write_refused_o (write_refused),
      .prot_fire_o     (prot_fire)
   );

   assign flag_set[FLAG_ERASE] = erase_refused;
   assign flag_set[FLAG_WRITE] = write_refused;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         memop_q <= '0;
         imr_q   <= '0;
         csel_q  <= '0;
      end else if (bus_we_i) begin
         case (bus_addr_i)
            OFS_MEMOP: memop_q <= bus_wdata_i;
            OFS_IMR:   imr_q   <= bus_wdata_i[NUM_FLAGS-1:0];
            OFS_CSEL:  csel_q  <= bus_wdata_i[CS_W-1:0];
            default:   ;
         endcase
      end
   end

   for (genvar b = 0; b < NUM_FLAGS; b++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            isr_q[b] <= 1'b0;
         end else begin
            isr_q[b] <= flag_set[b] | (isr_q[b] & ~(isr_we & bus_wdata_i[b]));
         end
      end
   end

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_o <= 1'b0;
         end else begin
            irq_o <= |(isr_q & imr_q);
         end
      end
   end else begin : g_irq_comb
      assign irq_o = |(isr_q & imr_q);
   end

   always_comb begin
      case (bus_addr_i)
         OFS_STATUS: bus_rdata_o = {25'd0, cfg.level[3], cfg.bottom, cfg.level[2:0], 2'b00};
         OFS_SID:    bus_rdata_o = sid_i;
         OFS_DEVID:  bus_rdata_o = devid_i;
         OFS_MEMOP:  bus_rdata_o = memop_q;
         OFS_ISR:    bus_rdata_o = {{(32-NUM_FLAGS){1'b0}}, isr_q};
         OFS_IMR:    bus_rdata_o = {{(32-NUM_FLAGS){1'b0}}, imr_q};
         OFS_CSEL:   bus_rdata_o = 32'(csel_q);
         default:    bus_rdata_o = 32'd0;
      endcase
   end

   assign op_prot_level_o  = cfg.level;
   assign op_prot_bottom_o = cfg.bottom;
   assign csel_o           = csel_q;

   assert_cfg_only_by_cmd_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !prot_fire |=> $stable(cfg));

   assert_w1c_erase_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (isr_we && bus_wdata_i[FLAG_ERASE] && !erase_refused) |=> !isr_q[FLAG_ERASE]);

   assert_set_wins_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      write_refused |=> isr_q[FLAG_WRITE]);

   assert_write_pass_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_i && !hit[1]) |=> (wr_ok_o && !$changed(isr_q[FLAG_WRITE]) || wr_ok_o));

   assert_refused_write_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_i && hit[1]) |=> !wr_ok_o);

endmodule

// File: tb/flashprot_top_tb.sv
module flashprot_top_tb_top;

   localparam int ADDR_W     = 20;
   localparam int SECT_SHIFT = 16;
   localparam int CS_W       = 2;
   localparam int NSW        = ADDR_W - SECT_SHIFT;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        bus_addr_i = '0;
   logic              bus_we_i = 1'b0;
   logic [31:0]       bus_wdata_i = '0;
   logic [31:0]       bus_rdata_o;
   logic [31:0]       sid_i = 32'hA5C3_0F17;
   logic [31:0]       devid_i = 32'h0020_0018;
   logic              mem_wr_i = 1'b0;
   logic [ADDR_W-1:0] mem_wr_addr_i = '0;
   logic              op_bulk_o;
   logic              op_sect_o;
   logic [NSW-1:0]    op_sect_idx_o;
   logic              op_prot_o;
   logic [3:0]        op_prot_level_o;
   logic              op_prot_bottom_o;
   logic              wr_ok_o;
   logic [CS_W-1:0]   csel_o;
   logic              irq_o;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   flashprot_top #(.ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT), .CS_W(CS_W), .IRQ_REG(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
      .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .sid_i(sid_i), .devid_i(devid_i),
      .mem_wr_i(mem_wr_i), .mem_wr_addr_i(mem_wr_addr_i), .op_bulk_o(op_bulk_o),
      .op_sect_o(op_sect_o), .op_sect_idx_o(op_sect_idx_o), .op_prot_o(op_prot_o),
      .op_prot_level_o(op_prot_level_o), .op_prot_bottom_o(op_prot_bottom_o),
      .wr_ok_o(wr_ok_o), .csel_o(csel_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr_i  = a;
      bus_wdata_i = d;
      bus_we_i    = 1'b1;
      @(negedge clk);
      bus_we_i    = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr_i = a;
      #1;
      d = bus_rdata_o;
   endtask

   task automatic mem_wr(input int s);
      @(negedge clk);
      mem_wr_i      = 1'b1;
      mem_wr_addr_i = ADDR_W'((s << SECT_SHIFT) | 16'h1234);
      @(negedge clk);
      mem_wr_i      = 1'b0;
   endtask

   function automatic bit exp_prot(input int lvl, input int tb, input int dv, input int s);
      int nl;
      int ns;
      int ll;
      int len;
      nl = dv - 22;
      if (nl < 0) nl = 0;
      if (nl > NSW) nl = NSW;
      ns = 1 << nl;
      if (lvl == 0) return 1'b0;
      ll = lvl - 1;
      if (ll > nl) ll = nl;
      len = 1 << ll;
      return (tb != 0) ? (s < len) : (s >= ns - len);
   endfunction

   function automatic int status_word(input int lvl, input int tb);
      return ((lvl & 7) << 2) | (((lvl >> 3) & 1) << 6) | ((tb & 1) << 5);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      bit p;

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "irq", irq_o, 0);
      check("R1", "pulses", {op_bulk_o, op_sect_o, op_prot_o, wr_ok_o}, 0);
      bus_rd(3'd0, rd); check("R1", "status", rd, 0);
      bus_rd(3'd4, rd); check("R1", "isr", rd, 0);
      bus_rd(3'd5, rd); check("R1", "imr", rd, 0);
      bus_rd(3'd3, rd); check("R1", "memop", rd, 0);
      check("R1", "csel", csel_o, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: register map behaviour
      bus_wr(3'd0, 32'hFFFF_FFFF);
      bus_rd(3'd0, rd); check("R2", "status write ignored", rd, 0);
      bus_rd(3'd1, rd); check("R2", "sid", rd, 32'hA5C3_0F17);
      bus_rd(3'd2, rd); check("R2", "devid", rd, 32'h0020_0018);
      bus_wr(3'd5, 32'hFFFF_FFFE);
      bus_rd(3'd5, rd); check("R2", "imr mask width", rd, 2);
      bus_wr(3'd6, 32'h0000_0007);
      bus_rd(3'd6, rd); check("R2", "csel readback", rd, 3);
      check("R2", "csel port", csel_o, 3);
      bus_wr(3'd7, 32'h1234_5678);
      bus_rd(3'd7, rd); check("R2", "unused offset", rd, 0);
      bus_wr(3'd5, 32'd0);

      // R11: unknown opcodes do nothing
      bus_wr(3'd3, 32'h0000_1F05);
      check("R11", "no pulse opc5", {op_bulk_o, op_sect_o, op_prot_o}, 0);
      bus_rd(3'd3, rd); check("R2", "memop readback", rd, 32'h0000_1F05);
      bus_rd(3'd0, rd); check("R11", "status unchanged", rd, 0);
      bus_wr(3'd3, 32'h0000_1F00);
      check("R11", "no pulse opc0", {op_bulk_o, op_sect_o, op_prot_o}, 0);
      bus_rd(3'd4, rd); check("R11", "flags unchanged", rd, 0);

      // Sweep array size, level, anchor, sector
      for (int dv = 20; dv <= 27; dv++) begin
         devid_i = 32'h0020_0000 | dv;
         for (int lvl = 0; lvl < 16; lvl++) begin
            for (int tb = 0; tb < 2; tb++) begin
               bus_wr(3'd3, 32'((tb << 12) | (lvl << 8) | 3));
               check("R3", "protect pulse", op_prot_o, 1);
               check("R3", "level port", op_prot_level_o, lvl);
               bus_rd(3'd0, rd); check("R3", "status bits", rd, status_word(lvl, tb));

               bus_wr(3'd3, 32'h0000_0001);
               check("R7", "bulk pulse", op_bulk_o, (lvl == 0) ? 1 : 0);
               bus_rd(3'd4, rd); check("R7", "bulk flag", rd[0], (lvl == 0) ? 0 : 1);
               if (lvl != 0) begin
                  bus_wr(3'd4, 32'd1);
                  bus_rd(3'd4, rd); check("R9", "clear erase flag", rd, 0);
               end

               for (int s = 0; s < (1 << NSW); s++) begin
                  p = exp_prot(lvl, tb, dv, s);
                  bus_wr(3'd3, 32'((s << 8) | 2));
                  check("R5", "sect pulse", op_sect_o, p ? 0 : 1);
                  if (!p) check("R5", "sect idx", op_sect_idx_o, s);
                  bus_rd(3'd4, rd); check("R6", "erase flag", rd[0], p);
                  if (p) bus_wr(3'd4, 32'd1);

                  mem_wr(s);
                  check("R8", "write ok", wr_ok_o, p ? 0 : 1);
                  bus_rd(3'd4, rd); check("R4", "write flag", rd[1], p);
                  if (p) bus_wr(3'd4, 32'd2);
               end
            end
         end
      end

      // R9: set wins over clear in the same cycle
      devid_i = 32'h0020_001A;
      bus_wr(3'd3, 32'h0000_1103);
      @(negedge clk);
      mem_wr_i      = 1'b1;
      mem_wr_addr_i = '0;
      bus_addr_i    = 3'd4;
      bus_wdata_i   = 32'd2;
      bus_we_i      = 1'b1;
      @(negedge clk);
      mem_wr_i = 1'b0;
      bus_we_i = 1'b0;
      bus_rd(3'd4, rd); check("R9", "set wins", rd[1], 1);
      bus_wr(3'd4, 32'd2);
      bus_rd(3'd4, rd); check("R9", "cleared", rd, 0);

      // R10: interrupt masking
      bus_wr(3'd3, 32'h0000_0002);
      bus_rd(3'd4, rd); check("R6", "erase flag sector0", rd, 1);
      check("R10", "masked off", irq_o, 0);
      bus_wr(3'd5, 32'd2);
      check("R10", "wrong mask bit", irq_o, 0);
      bus_wr(3'd5, 32'd1);
      check("R10", "irq raised", irq_o, 1);
      bus_wr(3'd4, 32'd1);
      check("R10", "irq drops", irq_o, 0);

      // R3: unprotect
      bus_wr(3'd3, 32'h0000_0003);
      bus_rd(3'd0, rd); check("R3", "unprotect", rd, 0);
      mem_wr(0);
      check("R8", "write after unprotect", wr_ok_o, 1);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule